// File: doc/BRIEF.md
# Indirect Configuration Window with Keyed Soft Reset

This block is the host-facing register front end of a serial-bus controller. A small 8-bit parallel host bus (address, write strobe, read strobe) reaches two locations in it: a selector register and a window register. The selector names one of several internal configuration registers. Reads and writes through the window reach whichever register the selector currently names. Those registers hold the controller's own bus address, a timeout count, an operating mode, and the low and high phase lengths of the serial clock. Their values leave the block as output ports, to be used by the bus engine and the clock generator, which live elsewhere.

One slot of the internal space is a reset key. It stores nothing. When the host writes the byte 0xA5 and then, as its very next write, the byte 0x5A to this slot, the block raises a soft-reset strobe for one clock. That strobe also returns every internal configuration register to its default. Any other pattern of writes throws the partial key away. Status, control and data registers of the controller sit at other host addresses, served by other logic. This block ignores writes to those addresses and returns zero for reads of them.

Top module: `cfg_window`

## Requirements
- R1: After synchronous reset the selector is 0x00 and the configuration outputs take their defaults: own address 0x00, timeout 0xFF, mode 0x00, clock low 0x9D, clock high 0x86. Both `soft_rst` and `rdata` are 0.
- R2: A write at host address `SEL_ADDR` (default 2) stores all 8 bits in the selector, and a read there returns them. A window access never changes the selector: it does not auto-increment.
- R3: A write at host address `WIN_ADDR` (default 3) goes to the register named by the selector: 0 own address, 1 timeout, 2 mode, 3 clock low, 4 clock high. The matching output shows the new value after the write's clock edge, and a window read returns it unchanged.
- R4: `rdata` is registered. It holds the read result one clock after `rd_en` is sampled, and keeps its value in cycles without a read. A read in the same cycle as a write returns the old value.
- R5: The mode register keeps only bits 1:0. Its upper bits read back as 0 and appear as 0 on `mode_val`.
- R6: Selector values 5 (the key slot) and 6 to 255 read back 0x00 through the window. Writing through the window at values 6 to 255 changes no output.
- R7: A window write of 0xA5 with the selector at 5, followed as the next host write by a window write of 0x5A with the selector still at 5, makes `soft_rst` high for exactly one clock, starting at the edge that samples the 0x5A write.
- R8: The key is dropped, and no pulse comes, when another host write of any kind falls between the two key bytes or when the second byte is not 0x5A. Host reads between the two bytes do not drop it. A fresh 0xA5 always starts a new key.
- R9: One clock after the `soft_rst` pulse, every configuration register is back at its default and the selector keeps its value.
- R10: Writes to host addresses other than `SEL_ADDR` and `WIN_ADDR` change nothing, and reads of those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (2) | Host register address |
| wr_en | input | 1 | Host write strobe, one sampled write per cycle |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| own_addr | output | 8 | Own bus address register |
| timeout_val | output | 8 | Timeout register |
| mode_val | output | 8 | Mode register (bits 1:0 live) |
| scl_low | output | 8 | Serial clock low-phase count |
| scl_high | output | 8 | Serial clock high-phase count |
| soft_rst | output | 1 | One-clock soft-reset strobe for the controller core |

## Verification
On every cycle the assertions check four things. The soft-reset strobe never lasts two clocks, and it only follows a 0x5A window write aimed at the key slot. The configuration outputs are at their defaults right after a strobe. The outputs and `rdata` stay still when nothing wrote or read them. Only the bench scenarios can show the rest: that an interrupted or wrong key gives no strobe, that reads between the key bytes are harmless, and that values read back through the selector and window path match what was written, with the mode masking and unused slots reading zero.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;
  localparam int DW       = 8;
  localparam int N_STORE  = 5;
  localparam int IDX_W    = 3;
  localparam logic [DW-1:0] KEY_FIRST  = 8'hA5;
  localparam logic [DW-1:0] KEY_SECOND = 8'h5A;

  typedef enum logic [IDX_W-1:0] {
    SLOT_OWN  = 3'd0,
    SLOT_TMO  = 3'd1,
    SLOT_MODE = 3'd2,
    SLOT_LOW  = 3'd3,
    SLOT_HIGH = 3'd4,
    SLOT_KEY  = 3'd5
  } slot_e;

  function automatic logic [DW-1:0] slot_default(input int i);
    case (i)
      1:       return 8'hFF;
      3:       return 8'h9D;
      4:       return 8'h86;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_mask(input int i);
    case (i)
      2:       return 8'h03;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cfg_key_seq.sv
module cfg_key_seq
  import cfg_window_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          any_wr,
  input  logic          key_wr,
  input  logic [DW-1:0] wdata,
  output logic          pulse
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      pulse <= 1'b0;
    end else if (any_wr) begin
      armed <= key_wr && (wdata == KEY_FIRST);
      pulse <= key_wr && armed && (wdata == KEY_SECOND);
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_window_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       we,
  input  logic [DW-1:0]              sel,
  input  logic [DW-1:0]              wdata,
  output logic [N_STORE-1:0][DW-1:0] q,
  output logic [DW-1:0]              rd_val
);
  logic sel_low;
  assign sel_low = (sel[DW-1:IDX_W] == '0);

  for (genvar i = 0; i < N_STORE; i++) begin : g_slot
    localparam logic [DW-1:0] DEF  = slot_default(i);
    localparam logic [DW-1:0] MASK = slot_mask(i);
    always_ff @(posedge clk) begin
      if (rst || clr)
        q[i] <= DEF;
      else if (we && sel_low && sel[IDX_W-1:0] == IDX_W'(i))
        q[i] <= wdata & MASK;
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel_low && sel[IDX_W-1:0] < IDX_W'(N_STORE))
      rd_val = q[sel[IDX_W-1:0]];
  end
endmodule

// File: rtl/cfg_window.sv
module cfg_window
  import cfg_window_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int SEL_ADDR = 2,
  parameter int WIN_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [7:0]        own_addr,
  output logic [7:0]        timeout_val,
  output logic [7:0]        mode_val,
  output logic [7:0]        scl_low,
  output logic [7:0]        scl_high,
  output logic              soft_rst
);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(SEL_ADDR);
  localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'(WIN_ADDR);

  logic [DW-1:0]              sel_q;
  logic [N_STORE-1:0][DW-1:0] cfg_q;
  logic [DW-1:0]              win_rd;
  logic                       win_wr, key_wr;

  assign win_wr = wr_en && (addr == A_WIN);
  assign key_wr = win_wr && (sel_q == DW'(SLOT_KEY));

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= '0;
    else if (wr_en && addr == A_SEL)
      sel_q <= wdata;
  end

  cfg_store u_store (
    .clk    (clk),
    .rst    (rst),
    .clr    (soft_rst),
    .we     (win_wr),
    .sel    (sel_q),
    .wdata  (wdata),
    .q      (cfg_q),
    .rd_val (win_rd)
  );

  cfg_key_seq u_key (
    .clk    (clk),
    .rst    (rst),
    .any_wr (wr_en),
    .key_wr (key_wr),
    .wdata  (wdata),
    .pulse  (soft_rst)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en) begin
      if (addr == A_SEL)      rdata <= sel_q;
      else if (addr == A_WIN) rdata <= win_rd;
      else                    rdata <= '0;
    end
  end

  assign own_addr    = cfg_q[SLOT_OWN];
  assign timeout_val = cfg_q[SLOT_TMO];
  assign mode_val    = cfg_q[SLOT_MODE];
  assign scl_low     = cfg_q[SLOT_LOW];
  assign scl_high    = cfg_q[SLOT_HIGH];
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk #(
  parameter int ADDR_W   = 2,
  parameter int WIN_ADDR = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [7:0]        sel_q,
  input logic [7:0]        own_addr,
  input logic [7:0]        timeout_val,
  input logic [7:0]        mode_val,
  input logic [7:0]        scl_low,
  input logic [7:0]        scl_high,
  input logic              soft_rst
);
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !soft_rst);

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(soft_rst) |-> ($past(wr_en) && $past(addr) == ADDR_W'(WIN_ADDR)
                         && $past(wdata) == 8'h5A && $past(sel_q) == 8'd5));

  assert_defaults_after_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (own_addr == 8'h00 && timeout_val == 8'hFF && mode_val == 8'h00
                  && scl_low == 8'h9D && scl_high == 8'h86));

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(soft_rst)) |->
      ($stable(own_addr) && $stable(timeout_val) && $stable(mode_val)
       && $stable(scl_low) && $stable(scl_high)));

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata));
endmodule

bind cfg_window cfg_window_chk #(.ADDR_W(ADDR_W), .WIN_ADDR(WIN_ADDR)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .sel_q(sel_q), .own_addr(own_addr),
  .timeout_val(timeout_val), .mode_val(mode_val), .scl_low(scl_low),
  .scl_high(scl_high), .soft_rst(soft_rst)
);

// File: tb/cfg_window_bench.sv
module cfg_window_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, own_addr, timeout_val, mode_val, scl_low, scl_high;
  logic       soft_rst;

  localparam logic [1:0] A_SEL = 2'd2, A_WIN = 2'd3;

  int checks = 0, errors = 0, pulses = 0, cycles = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #2 clk = ~clk;

  cfg_window u_cfg_window (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .own_addr(own_addr),
    .timeout_val(timeout_val), .mode_val(mode_val), .scl_low(scl_low),
    .scl_high(scl_high), .soft_rst(soft_rst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) rd_seen <= rd_en && !rst;

  // monitor: compares read results against the scoreboard
  always @(negedge clk) begin
    if (soft_rst) pulses++;
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected read actual=%0h expected=none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    summary();
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_defaults(input string tag);
    check({tag, " own"}, own_addr, 8'h00);
    check({tag, " tmo"}, timeout_val, 8'hFF);
    check({tag, " mode"}, mode_val, 8'h00);
    check({tag, " low"}, scl_low, 8'h9D);
    check({tag, " high"}, scl_high, 8'h86);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_defaults("R1");
    check("R1 soft_rst", soft_rst, 1'b0);
    check("R1 rdata", rdata, 8'h00);
    rd(A_SEL, 8'h00, "R1 selector");

    // R2 selector full width
    wr(A_SEL, 8'hC3);
    rd(A_SEL, 8'hC3, "R2 selector readback");

    // R3 own address round trip, no auto-increment
    wr(A_SEL, 8'd0);
    wr(A_WIN, 8'h4B);
    check("R3 own_addr port", own_addr, 8'h4B);
    rd(A_WIN, 8'h4B, "R3 own readback");
    rd(A_WIN, 8'h4B, "R2 no auto-increment");
    rd(A_SEL, 8'h00, "R2 selector kept");
    wr(A_SEL, 8'd1); wr(A_WIN, 8'h20);
    check("R3 timeout port", timeout_val, 8'h20);
    wr(A_SEL, 8'd3); wr(A_WIN, 8'h11);
    wr(A_SEL, 8'd4); wr(A_WIN, 8'h22);
    check("R3 low port", scl_low, 8'h11);
    check("R3 high port", scl_high, 8'h22);
    rd(A_WIN, 8'h22, "R3 high readback");

    // R5 mode masking
    wr(A_SEL, 8'd2); wr(A_WIN, 8'hFE);
    check("R5 mode port", mode_val, 8'h02);
    rd(A_WIN, 8'h02, "R5 mode readback");

    // R4 read same cycle as write returns old value
    @(negedge clk);
    addr = A_WIN; wdata = 8'h01; wr_en = 1'b1; rd_en = 1'b1;
    exp_q.push_back(8'h02); tag_q.push_back("R4 read-before-write");
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 rdata hold", rdata, 8'h02);
    check("R4 write landed", mode_val, 8'h01);

    // R6 unused slots
    wr(A_SEL, 8'd5);
    rd(A_WIN, 8'h00, "R6 key slot reads zero");
    wr(A_SEL, 8'd7); wr(A_WIN, 8'h77);
    rd(A_WIN, 8'h00, "R6 slot 7 reads zero");
    wr(A_SEL, 8'h40); wr(A_WIN, 8'h77);
    check("R6 own unchanged", own_addr, 8'h4B);
    check("R6 low unchanged", scl_low, 8'h11);

    // R10 other host addresses
    wr(2'd0, 8'h99); wr(2'd1, 8'h99);
    rd(2'd1, 8'h00, "R10 other address reads zero");
    rd(A_SEL, 8'h40, "R10 selector untouched");
    check("R10 own unchanged", own_addr, 8'h4B);

    // R8 interrupted key and wrong second byte
    wr(A_SEL, 8'd5);
    pulses = 0;
    wr(A_WIN, 8'hA5); wr(2'd0, 8'h00); wr(A_WIN, 8'h5A);
    wr(A_WIN, 8'hA5); wr(A_WIN, 8'h5B); wr(A_WIN, 8'h5A);
    wr(A_WIN, 8'h5A); wr(A_WIN, 8'hA5); wr(A_SEL, 8'd5); wr(A_WIN, 8'h5A);
    repeat (2) @(negedge clk);
    check("R8 no pulse on broken key", pulses, 0);
    check("R8 config kept", scl_high, 8'h22);

    // R7 valid key with a read between bytes, and R9 defaults restored
    wr(A_WIN, 8'hA5);
    rd(A_WIN, 8'h00, "R8 read between key bytes");
    @(negedge clk);
    addr = A_WIN; wdata = 8'h5A; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 pulse high", soft_rst, 1'b1);
    @(negedge clk);
    check("R7 pulse one cycle", soft_rst, 1'b0);
    check("R7 pulse count", pulses, 1);
    check_defaults("R9");
    rd(A_SEL, 8'h05, "R9 selector kept");

    // R8 repeated first byte restarts the key
    pulses = 0;
    wr(A_WIN, 8'hA5); wr(A_WIN, 8'hA5); wr(A_WIN, 8'h5A);
    @(negedge clk);
    check("R8 restart pulse", pulses, 1);

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule